// File: doc/BRIEF.md
# Load-Use Interlock Detector

This block sits in the decode stage of a five-stage in-order integer pipeline. Each cycle it looks at two 32-bit instruction words: the one in decode, held in the fetch/decode pipeline register, and the one in execute, held in the decode/execute pipeline register. Alongside each word it receives a small decoded class code. When the execute-stage instruction is a load whose target register is a source that the decode-stage instruction reads, the loaded value will not exist in time. In that case the block raises a stall.

A stall does two things in the same cycle. It drops the write enable for the PC and the fetch/decode register, so fetch and decode are held. It also asks the decode/execute register to take an all-zero control word, so that a bubble goes down the pipe. The check needs only three equality comparators. Which of them count depends on the decode-stage class. Register 0 never causes a stall.

After one stall cycle the load has moved on to memory access, and forwarding supplies the value from then on. A one-bit guard register therefore limits each load-use pair to a single stall cycle.

Top module: `load_use_interlock`

## Requirements
- R1: No stall is raised unless the execute-stage class is LOAD. Class codes on the 3-bit class inputs: 0 other, 1 register-register ALU, 2 ALU-immediate, 3 LOAD, 4 store, 5 branch, 6 and 7 other.
- R2: With a LOAD in execute and a register-register ALU instruction in decode, a stall is raised when the load's rt equals the decode instruction's rs.
- R3: With a LOAD in execute and a register-register ALU instruction in decode, a stall is raised when the load's rt equals the decode instruction's rt.
- R4: With a LOAD in execute and a load, store, ALU-immediate or branch in decode, a stall is raised when the load's rt equals the decode rs. A match on the decode rt alone raises none.
- R5: A load whose rt is register 0 never causes a stall.
- R6: In every stall cycle, pc_ifid_en is low and idex_bubble is high in that same cycle. In every other cycle, pc_ifid_en is high and idex_bubble is low.
- R7: A stall lasts at most one cycle. The cycle after a stall never stalls, even if the inputs still show a hazard.
- R8: A decode-stage instruction of class 0, 6 or 7 never causes a stall.
- R9: Field positions in the 32-bit word are rs = bits 25:21 and rt = bits 20:16. The opcode (31:26), rd (15:11) and bits 10:0 take no part in the comparison, so a match on rd alone gives no stall.
- R10: While reset is active, and in the first cycle after it, the guard is clear. With hazard-free inputs, the outputs show no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the guard register |
| id_class | input | 3 | Class code of the decode-stage instruction |
| id_instr | input | 32 | Decode-stage instruction word |
| ex_class | input | 3 | Class code of the execute-stage instruction |
| ex_instr | input | 32 | Execute-stage instruction word |
| stall | output | 1 | Load-use hazard detected this cycle |
| pc_ifid_en | output | 1 | Write enable for the PC and fetch/decode register |
| idex_bubble | output | 1 | Load zero control into the decode/execute register |

## Verification
The only state is the one-cycle guard, and errors in it appear at the ports at once. If the guard is stuck set, the next real hazard passes with no stall in its first cycle. If it is stuck clear, a persisting hazard shows stall for two consecutive cycles. A wrong comparator or a wrong field slice shows up in the same cycle as a missing or spurious stall. The bench compares against a behavioural model on every cycle, using directed cases and a mixed stream of register numbers drawn from a small range, so that matches happen often.

// File: rtl/load_use_interlock.sv
module load_use_interlock #(
  parameter int XLEN     = 32,
  parameter int RIDX_W   = 5,
  parameter int CLASS_W  = 3,
  parameter int RS_LSB   = 21,
  parameter int RT_LSB   = 16,
  parameter int RD_LSB   = 11,
  parameter logic [CLASS_W-1:0] C_RR    = 3'd1,
  parameter logic [CLASS_W-1:0] C_IMM   = 3'd2,
  parameter logic [CLASS_W-1:0] C_LOAD  = 3'd3,
  parameter logic [CLASS_W-1:0] C_STORE = 3'd4,
  parameter logic [CLASS_W-1:0] C_BR    = 3'd5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CLASS_W-1:0] id_class,
  input  logic [XLEN-1:0]    id_instr,
  input  logic [CLASS_W-1:0] ex_class,
  input  logic [XLEN-1:0]    ex_instr,
  output logic               stall,
  output logic               pc_ifid_en,
  output logic               idex_bubble
);

  logic [RIDX_W-1:0] id_rs, id_rt, ld_rt;
  logic              ex_is_load, id_rr, id_one_src;
  logic              hit_rs, hit_rt, hazard;
  logic              stall_q;

  assign id_rs = id_instr[RS_LSB +: RIDX_W];
  assign id_rt = id_instr[RT_LSB +: RIDX_W];
  assign ld_rt = ex_instr[RT_LSB +: RIDX_W];

  assign ex_is_load = (ex_class == C_LOAD);
  assign id_rr      = (id_class == C_RR);
  assign id_one_src = (id_class == C_IMM) || (id_class == C_LOAD) ||
                      (id_class == C_STORE) || (id_class == C_BR);

  assign hit_rs = (ld_rt == id_rs);
  assign hit_rt = (ld_rt == id_rt);

  assign hazard = ex_is_load && (ld_rt != '0) &&
                  ((id_rr && (hit_rs || hit_rt)) || (id_one_src && hit_rs));

  assign stall       = hazard && !stall_q;
  assign pc_ifid_en  = !stall;
  assign idex_bubble = stall;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall;
  end

  p_load_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_class != C_LOAD) |-> !stall);

  p_zero_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_instr[RT_LSB +: RIDX_W] == '0) |-> !stall);

  p_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_ifid_en && idex_bubble));

  p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  p_single_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((id_class != C_RR) &&
     (ex_instr[RT_LSB +: RIDX_W] != id_instr[RS_LSB +: RIDX_W])) |-> !stall);

  p_other_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (id_class == 3'd0 || id_class == 3'd6 || id_class == 3'd7) |-> !stall);

  p_rd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((id_instr[RD_LSB +: RIDX_W] == ex_instr[RT_LSB +: RIDX_W]) &&
     (id_instr[RS_LSB +: RIDX_W] != ex_instr[RT_LSB +: RIDX_W]) &&
     (id_instr[RT_LSB +: RIDX_W] != ex_instr[RT_LSB +: RIDX_W])) |-> !stall);

  p_inputs_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(stall_q) && !stall_q &&
     $stable({id_class, id_instr, ex_class, ex_instr})) |-> $stable(stall));

endmodule

// File: tb/load_use_interlock_test.sv
module load_use_interlock_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  id_class, ex_class;
  logic [31:0] id_instr, ex_instr;
  logic        stall, pc_ifid_en, idex_bubble;

  int checks = 0;
  int failures = 0;
  bit prev_stall = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_use_interlock uut (
    .clk(clk), .rst_n(rst_n),
    .id_class(id_class), .id_instr(id_instr),
    .ex_class(ex_class), .ex_instr(ex_instr),
    .stall(stall), .pc_ifid_en(pc_ifid_en), .idex_bubble(idex_bubble)
  );

  function automatic logic [31:0] mk(int rs, int rt, int rd);
    return {6'h2b, rs[4:0], rt[4:0], rd[4:0], 11'h5a5};
  endfunction

  function automatic bit model_hz(int idc, logic [31:0] idw, int exc, logic [31:0] exw);
    int lrt, rs, rt;
    lrt = int'(exw[20:16]);
    rs  = int'(idw[25:21]);
    rt  = int'(idw[20:16]);
    if (exc != 3 || lrt == 0) return 0;
    if (idc == 1) return (lrt == rs) || (lrt == rt);
    if (idc == 2 || idc == 3 || idc == 4 || idc == 5) return lrt == rs;
    return 0;
  endfunction

  task automatic check_out(bit exp, string tag);
    checks++;
    if (stall !== exp || pc_ifid_en !== !exp || idex_bubble !== exp) begin
      failures++;
      $display("FAIL %s: stall/en/bubble=%b%b%b expected %b%b%b",
               tag, stall, pc_ifid_en, idex_bubble, exp, !exp, exp);
    end
  endtask

  task automatic step(int idc, logic [31:0] idw, int exc, logic [31:0] exw, string tag);
    bit exp;
    @(negedge clk);
    id_class = idc[2:0]; id_instr = idw;
    ex_class = exc[2:0]; ex_instr = exw;
    #1;
    exp = model_hz(idc, idw, exc, exw) && !prev_stall;
    check_out(exp, tag);
    @(posedge clk);
    prev_stall = exp;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0;
    id_class = 3'd0; ex_class = 3'd0;
    id_instr = mk(1, 2, 3); ex_instr = mk(4, 5, 6);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out(1'b0, "R10 in reset");
    rst_n = 1'b1;
    prev_stall = 0;
    step(1, mk(5, 6, 7), 0, mk(1, 2, 3), "R10 after reset");

    step(1, mk(5, 6, 7), 1, mk(1, 5, 3), "R1 ex rr");
    step(1, mk(5, 6, 7), 2, mk(1, 6, 3), "R1 ex imm");
    step(1, mk(5, 6, 7), 4, mk(1, 5, 3), "R1 ex store");

    step(1, mk(5, 6, 7), 3, mk(1, 5, 3), "R2 rs match");
    step(1, mk(5, 6, 7), 3, mk(1, 5, 3), "R7 persisting hazard");
    step(1, mk(5, 6, 7), 0, mk(0, 0, 0), "R7 bubble follows");

    step(1, mk(8, 9, 10), 3, mk(2, 9, 4), "R3 rt match");
    step(0, mk(8, 9, 10), 0, mk(0, 0, 0), "R6 idle");

    step(2, mk(11, 12, 1), 3, mk(3, 11, 4), "R4 imm rs");
    step(0, mk(0, 0, 0), 0, mk(0, 0, 0), "R6 idle");
    step(3, mk(13, 14, 1), 3, mk(3, 13, 4), "R4 load rs");
    step(0, mk(0, 0, 0), 0, mk(0, 0, 0), "R6 idle");
    step(4, mk(15, 16, 1), 3, mk(3, 15, 4), "R4 store rs");
    step(0, mk(0, 0, 0), 0, mk(0, 0, 0), "R6 idle");
    step(5, mk(17, 18, 1), 3, mk(3, 17, 4), "R4 branch rs");
    step(0, mk(0, 0, 0), 0, mk(0, 0, 0), "R6 idle");
    step(2, mk(11, 12, 1), 3, mk(3, 12, 4), "R4 imm rt ignored");
    step(4, mk(11, 12, 1), 3, mk(3, 12, 4), "R4 store rt ignored");
    step(5, mk(11, 12, 1), 3, mk(3, 12, 4), "R4 branch rt ignored");

    step(1, mk(0, 0, 0), 3, mk(5, 0, 0), "R5 r0 rr");
    step(2, mk(0, 3, 0), 3, mk(5, 0, 0), "R5 r0 imm");

    step(0, mk(20, 21, 0), 3, mk(1, 20, 0), "R8 class0");
    step(6, mk(20, 21, 0), 3, mk(1, 21, 0), "R8 class6");
    step(7, mk(20, 21, 0), 3, mk(1, 20, 0), "R8 class7");

    step(1, mk(2, 3, 9), 3, mk(9, 9, 9), "R9 rd only");
    step(1, {6'h23, 5'd4, 5'd6, 5'd0, 11'h0}, 3, {6'h23, 5'd30, 5'd4, 5'd4, 11'h7ff}, "R9 rs bits");

    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      int idc, exc;
      logic [31:0] idw, exw;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      idc = int'(lfsr[2:0]);
      exc = lfsr[3] ? 3 : int'(lfsr[6:4]);
      idw = mk(int'(lfsr[8:7]), int'(lfsr[10:9]), int'(lfsr[12:11]));
      exw = mk(int'(lfsr[14:13]), int'(lfsr[15:14]), int'(lfsr[1:0]));
      step(idc, idw, exc, exw, "R2 R3 R4 R7 mixed");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule